// File: doc/BRIEF.md
# FIFO-Threshold DMA Request Handshake

This block sits between a byte-wide parallel-port data path and an external DMA controller that moves 16-bit words. It holds a small byte FIFO, tracks its occupancy, and drives an active-low request line. In the forward direction the DMA controller fills the FIFO one word per acknowledge and the port drains it a byte at a time. In the reverse direction the port fills the FIFO a byte at a time and each acknowledge drains one word. The acknowledge carries no address.

The request turns on when occupancy crosses a programmable threshold. In the forward direction that means occupancy falls below it. In the reverse direction it means occupancy rises above it. Once on, the request stays on until the FIFO has fewer than two free bytes (forward) or fewer than two stored bytes (reverse). This gives hysteresis between the turn-on and turn-off points.

Clearing the enable or changing direction drops the request at once. The port-side byte streams use valid/ready. A byte moves only on a cycle where both valid and ready are high, and either side may hold off the other indefinitely. Only the stream that matches the current direction is ever active. The FIFO depth must be a power of two.

Top module: `fifo_dma_handshake`

## Requirements
- R1: While reset is held and on the first cycle after it, `dma_req_n` is 1 and `pout_valid` is 0, because the FIFO starts empty.
- R2: In forward mode (`dir_rev`=0) with `dma_en`=1, `dma_req_n` goes to 0 one clock edge after occupancy is seen below `thresh`.
- R3: In forward mode, `dma_req_n` returns to 1 in the same cycle that occupancy exceeds DEPTH-2. It stays 1 until occupancy is again below `thresh`.
- R4: In reverse mode (`dir_rev`=1) with `dma_en`=1, `dma_req_n` goes to 0 one clock edge after occupancy is seen above `thresh`.
- R5: In reverse mode, `dma_req_n` returns to 1 in the same cycle that occupancy drops below 2.
- R6: When `dma_en` is 0, `dma_req_n` is 1 without waiting for a clock edge. A change of `dir_rev` also forces `dma_req_n` to 1 without waiting for an edge. After a direction change the request can turn on again no sooner than two edges later.
- R7: In forward mode, each cycle with `dma_en`=1 and `dma_ack_n`=0 stores `dma_wdata` as two bytes. Bits 7:0 are stored first and leave the port first. If fewer than two bytes are free, the acknowledge is ignored.
- R8: In reverse mode, `dma_rdata` shows the two oldest bytes, with the oldest in bits 7:0. Each cycle with `dma_en`=1 and `dma_ack_n`=0 removes them. If fewer than two bytes are stored, the acknowledge is ignored.
- R9: `pout_valid` is 1 only in forward mode with a non-empty FIFO. `pin_ready` is 1 only in reverse mode with a non-full FIFO. Occupancy never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dma_en | input | 1 | Enables DMA requests and acknowledges |
| dir_rev | input | 1 | 0 = forward (DMA fills FIFO), 1 = reverse (DMA drains FIFO) |
| thresh | input | CW | Request turn-on threshold in bytes |
| dma_req_n | output | 1 | DMA request, active low |
| dma_ack_n | input | 1 | DMA acknowledge, active low, one word per low cycle |
| dma_wdata | input | 16 | Word written by the DMA controller (forward) |
| dma_rdata | output | 16 | Word offered to the DMA controller (reverse) |
| pin_valid | input | 1 | Port byte into FIFO is valid (reverse) |
| pin_ready | output | 1 | FIFO can take a port byte |
| pin_data | input | 8 | Port byte into FIFO |
| pout_valid | output | 1 | FIFO byte toward the port is valid (forward) |
| pout_ready | input | 1 | Port takes the byte |
| pout_data | output | 8 | FIFO byte toward the port |

## Verification
The turn-on of the request is due one edge after the occupancy that triggers it is stored. Occupancy is updated on the edge that applies an acknowledge or a stream handshake, so the request turns on two edges after the handshake that causes the crossing. The turn-off paths are combinational on stored occupancy, enable and direction. The bench therefore drives every input one time unit after a rising edge, samples turn-off results in that same cycle (the enable and direction cases without any edge), and samples turn-on results only after the counted number of edges. Data words and port bytes are compared before the handshake edge that consumes them.

// File: rtl/fdh_pkg.sv
package fdh_pkg;
  typedef logic [7:0]  byte_t;
  typedef logic [15:0] word_t;
  localparam int WORD_BYTES = 2;
endpackage

// File: rtl/fdh_byte_fifo.sv
module fdh_byte_fifo
  import fdh_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    push_cnt,
  input  word_t         push_data,
  input  logic [1:0]    pop_cnt,
  output word_t         head,
  output logic [CW-1:0] occ
);
  byte_t         mem [DEPTH];
  logic [AW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    for (int j = 0; j < WORD_BYTES; j++) begin
      if (push_cnt > 2'(j)) mem[wp + AW'(j)] <= push_data[8*j +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else begin
      wp  <= wp + AW'(push_cnt);
      rp  <= rp + AW'(pop_cnt);
      occ <= occ + CW'(push_cnt) - CW'(pop_cnt);
    end
  end

  assign head = {mem[rp + AW'(1)], mem[rp]};
endmodule

// File: rtl/fdh_req_ctl.sv
module fdh_req_ctl #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          dir_rev,
  input  logic [CW-1:0] thresh,
  input  logic [CW-1:0] occ,
  output logic          req_n
);
  localparam logic [CW-1:0] FULL_LIM = CW'(DEPTH - 2);
  localparam logic [CW-1:0] EMPTY_LIM = CW'(2);

  logic dir_q, req_q;
  logic start, stop, keep;

  // Turn-on and turn-off points differ, giving hysteresis.
  assign start = dir_rev ? (occ > thresh) : (occ < thresh);
  assign stop  = dir_rev ? (occ < EMPTY_LIM) : (occ > FULL_LIM);
  assign keep  = en && (dir_rev == dir_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      dir_q <= dir_rev;
      req_q <= keep && (req_q ? !stop : start);
    end
  end

  assign req_n = !(req_q && keep && !stop);
endmodule

// File: rtl/fifo_dma_handshake.sv
module fifo_dma_handshake
  import fdh_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dma_en,
  input  logic          dir_rev,
  input  logic [CW-1:0] thresh,
  output logic          dma_req_n,
  input  logic          dma_ack_n,
  input  logic [15:0]   dma_wdata,
  output logic [15:0]   dma_rdata,
  input  logic          pin_valid,
  output logic          pin_ready,
  input  logic [7:0]    pin_data,
  output logic          pout_valid,
  input  logic          pout_ready,
  output logic [7:0]    pout_data
);
  localparam logic [CW-1:0] ROOM_LIM = CW'(DEPTH - WORD_BYTES);
  localparam logic [CW-1:0] WORD_LIM = CW'(WORD_BYTES);
  localparam logic [CW-1:0] FULL     = CW'(DEPTH);

  logic [CW-1:0] occ;
  word_t         head, push_data;
  logic [1:0]    push_cnt, pop_cnt;
  logic          ack, fwd_acc, rev_acc, pin_fire, pout_fire;

  assign ack     = !dma_ack_n && dma_en;
  assign fwd_acc = ack && !dir_rev && (occ <= ROOM_LIM);
  assign rev_acc = ack &&  dir_rev && (occ >= WORD_LIM);

  assign pin_ready  = dir_rev && (occ != FULL);
  assign pout_valid = !dir_rev && (occ != '0);
  assign pin_fire   = pin_valid && pin_ready;
  assign pout_fire  = pout_valid && pout_ready;

  assign push_cnt  = fwd_acc ? 2'd2 : (pin_fire ? 2'd1 : 2'd0);
  assign pop_cnt   = rev_acc ? 2'd2 : (pout_fire ? 2'd1 : 2'd0);
  assign push_data = fwd_acc ? dma_wdata : {8'h00, pin_data};

  fdh_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push_cnt  (push_cnt),
    .push_data (push_data),
    .pop_cnt   (pop_cnt),
    .head      (head),
    .occ       (occ)
  );

  fdh_req_ctl #(.DEPTH(DEPTH)) u_req (
    .clk     (clk),
    .rst     (rst),
    .en      (dma_en),
    .dir_rev (dir_rev),
    .thresh  (thresh),
    .occ     (occ),
    .req_n   (dma_req_n)
  );

  assign dma_rdata = head;
  assign pout_data = head[7:0];
endmodule

// File: rtl/fdh_checker.sv
module fdh_checker #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          dma_en,
  input logic          dir_rev,
  input logic [CW-1:0] thresh,
  input logic [CW-1:0] occ,
  input logic          dma_req_n,
  input logic          pin_ready,
  input logic          pout_valid
);
  AST_REQ_OFF_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !dma_en |-> dma_req_n); // R6
  AST_FWD_TURN_ON: assert property (@(posedge clk) disable iff (rst)
    ($fell(dma_req_n) && !dir_rev) |-> ($past(occ) < $past(thresh))); // R2
  AST_FWD_TURN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!dir_rev && occ > CW'(DEPTH - 2)) |-> dma_req_n); // R3
  AST_REV_TURN_ON: assert property (@(posedge clk) disable iff (rst)
    ($fell(dma_req_n) && dir_rev) |-> ($past(occ) > $past(thresh))); // R4
  AST_REV_TURN_OFF: assert property (@(posedge clk) disable iff (rst)
    (dir_rev && occ < CW'(2)) |-> dma_req_n); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH)); // R9
  AST_STREAM_DIR: assert property (@(posedge clk) disable iff (rst)
    !(pin_ready && pout_valid)); // R9
endmodule

bind fifo_dma_handshake fdh_checker #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dma_en     (dma_en),
  .dir_rev    (dir_rev),
  .thresh     (thresh),
  .occ        (occ),
  .dma_req_n  (dma_req_n),
  .pin_ready  (pin_ready),
  .pout_valid (pout_valid)
);

// File: tb/fifo_dma_handshake_test.sv
module fifo_dma_handshake_test;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dma_en = 1'b0, dir_rev = 1'b0;
  logic [CW-1:0] thresh = '0;
  logic          dma_req_n, dma_ack_n = 1'b1;
  logic [15:0]   dma_wdata = '0, dma_rdata;
  logic          pin_valid = 1'b0, pin_ready;
  logic [7:0]    pin_data = '0;
  logic          pout_valid, pout_ready = 1'b0;
  logic [7:0]    pout_data;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fifo_dma_handshake #(.DEPTH(DEPTH)) uut (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic test_reset();
    repeat (3) tick();
    check("R1 req_n in reset", dma_req_n, 1);
    check("R1 pout_valid in reset", pout_valid, 0);
    rst = 1'b0;
    tick();
    check("R1 req_n after reset", dma_req_n, 1);
    check("R1 pout_valid after reset", pout_valid, 0);
  endtask

  task automatic test_forward();
    thresh = CW'(4); dma_en = 1'b1;
    check("R2 req_n before edge", dma_req_n, 1);
    check("R9 pin_ready forward", pin_ready, 0);
    tick();
    check("R2 req_n on", dma_req_n, 0);
    for (int i = 0; i < 8; i++) begin
      dma_ack_n = 1'b0;
      dma_wdata = {8'hA0 + 8'(i), 8'hB0 + 8'(i)};
      tick();
      check("R3 req_n during fill", dma_req_n, (i == 7) ? 1 : 0);
    end
    dma_wdata = 16'hDEAD;
    tick();
    dma_ack_n = 1'b1;
    check("R3 req_n stays off when full", dma_req_n, 1);
    pout_ready = 1'b1;
    for (int k = 0; k < 16; k++) begin
      check("R7 pout_valid", pout_valid, 1);
      check("R7 byte order", pout_data,
            (k % 2 == 0) ? 8'hB0 + k / 2 : 8'hA0 + k / 2);
      tick();
      check("R3 hysteresis", dma_req_n, (k + 1 >= 14) ? 0 : 1);
    end
    pout_ready = 1'b0;
    check("R7 ack when full ignored", pout_valid, 0);
  endtask

  task automatic test_immediate_off();
    dir_rev = 1'b1; #1;
    check("R6 dir change off", dma_req_n, 1);
    tick();
    dir_rev = 1'b0;
    tick();
    check("R6 still off one edge after return", dma_req_n, 1);
    tick();
    check("R6 on again", dma_req_n, 0);
    dma_en = 1'b0; #1;
    check("R6 disable off", dma_req_n, 1);
  endtask

  task automatic test_reverse();
    dma_en = 1'b1; dir_rev = 1'b1; thresh = CW'(6);
    tick();
    check("R9 pout_valid reverse", pout_valid, 0);
    check("R9 pin_ready reverse", pin_ready, 1);
    pin_valid = 1'b1;
    for (int k = 0; k < 7; k++) begin
      pin_data = 8'h30 + 8'(k);
      tick();
      check("R4 req_n while filling", dma_req_n, 1);
    end
    pin_valid = 1'b0;
    tick();
    check("R4 req_n on", dma_req_n, 0);
    for (int w = 0; w < 3; w++) begin
      check("R8 rdata", dma_rdata, {8'h31 + 8'(2 * w), 8'h30 + 8'(2 * w)});
      dma_ack_n = 1'b0;
      tick();
      dma_ack_n = 1'b1;
      check("R5 req_n during drain", dma_req_n, (w == 2) ? 1 : 0);
    end
    dma_ack_n = 1'b0;
    tick();
    dma_ack_n = 1'b1;
    check("R5 req_n off", dma_req_n, 1);
    dma_en = 1'b0; dir_rev = 1'b0; #1;
    check("R8 ack with one byte ignored", pout_valid, 1);
    check("R8 leftover byte", pout_data, 8'h36);
    pout_ready = 1'b1;
    tick();
    pout_ready = 1'b0;
    check("R8 FIFO empty after leftover", pout_valid, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    test_reset();
    test_forward();
    test_immediate_off();
    test_reverse();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule